// File: doc/BRIEF.md
# Hill-Climbing Window Size Controller

This block picks how many bank groups of an instruction window stay enabled. The window size is always a power of two, and the controller adjusts it by hill climbing. During a measurement round it runs one interval at the present size, one at half that size and one at double that size. A fixed number of committed instructions ends each interval. For every interval the block adds up the committed instructions, the elapsed cycles and the consumed energy that outside counters report each cycle. Once the three trials are done it moves to the size that gave the best performance-cubed-per-watt figure. This choice is the same as minimising energy times delay squared. The window then stays at that size for a programmable number of intervals before the next round starts.

The controller has four states. In STEADY it counts completed intervals at the chosen size. When the hold count is reached it moves to TRIAL_CUR without changing the size. When the TRIAL_CUR interval ends it records the result and moves to TRIAL_HALF at half size. When the TRIAL_HALF interval ends it compares the result with the best so far and moves to TRIAL_DBL at double the original size. When the TRIAL_DBL interval ends it compares again and returns to STEADY at the winning size. The enabled group count is presented as a port. A one-cycle reconfiguration request marks every change of that count.

Top module: `wsc_window_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `grp_count` equals the initial window size divided by the group size (4 groups by default), `cfg_req` is 0 and the controller is in STEADY.
- R2: An interval ends in the clock cycle in which the running sum of `commit_in` reaches or exceeds INSN_LIMIT. That cycle's commits, one cycle and that cycle's energy are included in the totals, and the next interval starts from zero in the following cycle.
- R3: In STEADY the size never changes. After `hold_intervals` completed intervals a round begins, and a value of 0 acts as 1. The first trial reuses the current size with no request.
- R4: Trials run in the fixed order current, half, double. Every change of `grp_count` is accompanied by `cfg_req` = 1 for exactly that one cycle, and `cfg_req` is 0 whenever `grp_count` keeps its value.
- R5: A half size below MIN_LOG2, or a double size above MAX_LOG2, is replaced by the current size, which is then measured again.
- R6: A candidate with totals (I, C, E) beats the stored best (Ib, Cb, Eb) exactly when I^3·Cb^2·Eb > Ib^3·C^2·E. When the TRIAL_DBL interval ends, the window moves to the best candidate.
- R7: Only a strictly better candidate replaces the stored best, so on equal figures the current size, which is measured first, is kept.
- R8: `grp_count` is always a single power of two between 2^(MIN_LOG2-GROUP_LOG2) and 2^(MAX_LOG2-GROUP_LOG2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| commit_in | input | CMT_W | Instructions committed in this cycle |
| energy_in | input | EN_W | Energy units consumed in this cycle |
| hold_intervals | input | HOLD_W | Number of STEADY intervals between rounds (0 acts as 1) |
| grp_count | output | MAX_LOG2-GROUP_LOG2+1 | Number of enabled bank groups |
| cfg_req | output | 1 | One-cycle pulse when grp_count changes |

## Verification
Every internal decision shows up at the ports in the cycle right after the interval that caused it. An accumulator that stops one cycle early or late moves the edge of the next `grp_count` change by at least one cycle. A wrong product in the figure of merit, or a wrong tie rule, sends the window to a different size at the end of the round. An error in the order of the states gives a wrong sequence of sizes among half, current and double. The bench's reference model predicts `grp_count` and `cfg_req` for every cycle. Any of these faults therefore appears as a mismatch within one interval, at the latest at the end of the round.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [1:0] {
        ST_STEADY    = 2'd0,
        ST_TRIAL_CUR = 2'd1,
        ST_TRIAL_HALF = 2'd2,
        ST_TRIAL_DBL = 2'd3
    } wsc_state_e;

endpackage

// File: rtl/wsc_interval_meter.sv
module wsc_interval_meter #(
    parameter int INSN_LIMIT = 1000000,
    parameter int CMT_W      = 4,
    parameter int EN_W       = 16,
    parameter int INS_W      = 20,
    parameter int CYC_W      = 32,
    parameter int ACC_EN_W   = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CMT_W-1:0]    commit_in,
    input  logic [EN_W-1:0]     energy_in,
    output logic                last_o,
    output logic [INS_W-1:0]    ins_tot_o,
    output logic [CYC_W-1:0]    cyc_tot_o,
    output logic [ACC_EN_W-1:0] en_tot_o
);

    logic [INS_W-1:0]    ins_acc;
    logic [CYC_W-1:0]    cyc_acc;
    logic [ACC_EN_W-1:0] en_acc;
    logic [ACC_EN_W:0]   en_sum;

    always_comb begin
        ins_tot_o = ins_acc + INS_W'(commit_in);
        cyc_tot_o = (&cyc_acc) ? cyc_acc : cyc_acc + 1'b1;
        en_sum    = {1'b0, en_acc} + (ACC_EN_W+1)'(energy_in);
        en_tot_o  = en_sum[ACC_EN_W] ? '1 : en_sum[ACC_EN_W-1:0];
        last_o    = (ins_tot_o >= INS_W'(INSN_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || last_o) begin
            ins_acc <= '0;
            cyc_acc <= '0;
            en_acc  <= '0;
        end else begin
            ins_acc <= ins_tot_o;
            cyc_acc <= cyc_tot_o;
            en_acc  <= en_tot_o;
        end
    end

    assert_acc_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_acc < INS_W'(INSN_LIMIT));

    assert_fresh_interval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (cyc_acc == '0 && ins_acc == '0));

endmodule

// File: rtl/wsc_size_step.sv
module wsc_size_step #(
    parameter int LOG_W    = 4,
    parameter int MIN_LOG2 = 7,
    parameter int MAX_LOG2 = 11
) (
    input  logic [LOG_W-1:0] base_log2,
    output logic [LOG_W-1:0] half_log2,
    output logic [LOG_W-1:0] dbl_log2
);

    always_comb begin
        half_log2 = (base_log2 > LOG_W'(MIN_LOG2)) ? base_log2 - 1'b1 : base_log2;
        dbl_log2  = (base_log2 < LOG_W'(MAX_LOG2)) ? base_log2 + 1'b1 : base_log2;
    end

endmodule

// File: rtl/wsc_ed2_compare.sv
module wsc_ed2_compare #(
    parameter int INS_W    = 20,
    parameter int CYC_W    = 32,
    parameter int ACC_EN_W = 48
) (
    input  logic [INS_W-1:0]    cand_ins,
    input  logic [CYC_W-1:0]    cand_cyc,
    input  logic [ACC_EN_W-1:0] cand_en,
    input  logic [INS_W-1:0]    best_ins,
    input  logic [CYC_W-1:0]    best_cyc,
    input  logic [ACC_EN_W-1:0] best_en,
    output logic                cand_wins
);

    localparam int PROD_W = 3*INS_W + 2*CYC_W + ACC_EN_W;

    logic [PROD_W-1:0] cand_side;
    logic [PROD_W-1:0] best_side;

    // Cross-multiplied form of ins^3 / (cyc^2 * energy): no divider.
    always_comb begin
        cand_side = PROD_W'(cand_ins) * PROD_W'(cand_ins) * PROD_W'(cand_ins)
                  * PROD_W'(best_cyc) * PROD_W'(best_cyc) * PROD_W'(best_en);
        best_side = PROD_W'(best_ins) * PROD_W'(best_ins) * PROD_W'(best_ins)
                  * PROD_W'(cand_cyc) * PROD_W'(cand_cyc) * PROD_W'(cand_en);
        cand_wins = (cand_side > best_side);
    end

endmodule

// File: rtl/wsc_window_ctrl.sv
module wsc_window_ctrl
    import wsc_pkg::*;
#(
    parameter int GROUP_LOG2 = 7,
    parameter int MIN_LOG2   = 7,
    parameter int MAX_LOG2   = 11,
    parameter int INIT_LOG2  = 9,
    parameter int INSN_LIMIT = 1000000,
    parameter int CMT_W      = 4,
    parameter int EN_W       = 16,
    parameter int CYC_W      = 32,
    parameter int ACC_EN_W   = 48,
    parameter int HOLD_W     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CMT_W-1:0]                 commit_in,
    input  logic [EN_W-1:0]                  energy_in,
    input  logic [HOLD_W-1:0]                hold_intervals,
    output logic [MAX_LOG2-GROUP_LOG2:0]     grp_count,
    output logic                             cfg_req
);

    localparam int GRP_W = MAX_LOG2 - GROUP_LOG2 + 1;
    localparam int LOG_W = $clog2(MAX_LOG2 + 1);
    localparam int INS_W = $clog2(INSN_LIMIT + 2**CMT_W);

    wsc_state_e           state, state_nxt;
    logic [LOG_W-1:0]     size_log2, size_nxt;
    logic [LOG_W-1:0]     base_log2, base_nxt;
    logic [LOG_W-1:0]     best_log2, best_log2_nxt;
    logic [INS_W-1:0]     best_ins, best_ins_nxt;
    logic [CYC_W-1:0]     best_cyc, best_cyc_nxt;
    logic [ACC_EN_W-1:0]  best_en, best_en_nxt;
    logic [HOLD_W-1:0]    hold_cnt, hold_cnt_nxt;
    logic [HOLD_W:0]      hold_done_cnt, hold_goal;

    logic                 last;
    logic [INS_W-1:0]     ins_tot;
    logic [CYC_W-1:0]     cyc_tot;
    logic [ACC_EN_W-1:0]  en_tot;
    logic                 cand_wins;
    logic [LOG_W-1:0]     half_log2, dbl_log2;

    wsc_interval_meter #(
        .INSN_LIMIT(INSN_LIMIT), .CMT_W(CMT_W), .EN_W(EN_W),
        .INS_W(INS_W), .CYC_W(CYC_W), .ACC_EN_W(ACC_EN_W)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .commit_in(commit_in), .energy_in(energy_in),
        .last_o(last), .ins_tot_o(ins_tot), .cyc_tot_o(cyc_tot), .en_tot_o(en_tot)
    );

    wsc_ed2_compare #(
        .INS_W(INS_W), .CYC_W(CYC_W), .ACC_EN_W(ACC_EN_W)
    ) u_cmp (
        .cand_ins(ins_tot), .cand_cyc(cyc_tot), .cand_en(en_tot),
        .best_ins(best_ins), .best_cyc(best_cyc), .best_en(best_en),
        .cand_wins(cand_wins)
    );

    wsc_size_step #(
        .LOG_W(LOG_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
    ) u_step (
        .base_log2(base_log2), .half_log2(half_log2), .dbl_log2(dbl_log2)
    );

    always_comb begin
        hold_done_cnt = {1'b0, hold_cnt} + 1'b1;
        hold_goal     = (hold_intervals == '0) ? (HOLD_W+1)'(1) : {1'b0, hold_intervals};
    end

    // Next-state and datapath decisions
    always_comb begin
        state_nxt     = state;
        size_nxt      = size_log2;
        base_nxt      = base_log2;
        best_log2_nxt = best_log2;
        best_ins_nxt  = best_ins;
        best_cyc_nxt  = best_cyc;
        best_en_nxt   = best_en;
        hold_cnt_nxt  = hold_cnt;
        unique case (state)
            ST_STEADY: begin
                if (last) begin
                    if (hold_done_cnt >= hold_goal) begin
                        state_nxt    = ST_TRIAL_CUR;
                        hold_cnt_nxt = '0;
                        base_nxt     = size_log2;
                    end else begin
                        hold_cnt_nxt = hold_done_cnt[HOLD_W-1:0];
                    end
                end
            end
            ST_TRIAL_CUR: begin
                if (last) begin
                    best_log2_nxt = base_log2;
                    best_ins_nxt  = ins_tot;
                    best_cyc_nxt  = cyc_tot;
                    best_en_nxt   = en_tot;
                    size_nxt      = half_log2;
                    state_nxt     = ST_TRIAL_HALF;
                end
            end
            ST_TRIAL_HALF: begin
                if (last) begin
                    if (cand_wins) begin
                        best_log2_nxt = size_log2;
                        best_ins_nxt  = ins_tot;
                        best_cyc_nxt  = cyc_tot;
                        best_en_nxt   = en_tot;
                    end
                    size_nxt  = dbl_log2;
                    state_nxt = ST_TRIAL_DBL;
                end
            end
            ST_TRIAL_DBL: begin
                if (last) begin
                    if (cand_wins) begin
                        best_log2_nxt = size_log2;
                        best_ins_nxt  = ins_tot;
                        best_cyc_nxt  = cyc_tot;
                        best_en_nxt   = en_tot;
                    end
                    size_nxt  = cand_wins ? size_log2 : best_log2;
                    state_nxt = ST_STEADY;
                end
            end
            default: state_nxt = ST_STEADY;
        endcase
    end

    // State and datapath register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_STEADY;
            size_log2 <= LOG_W'(INIT_LOG2);
            base_log2 <= LOG_W'(INIT_LOG2);
            best_log2 <= LOG_W'(INIT_LOG2);
            best_ins  <= '0;
            best_cyc  <= '0;
            best_en   <= '0;
            hold_cnt  <= '0;
        end else begin
            state     <= state_nxt;
            size_log2 <= size_nxt;
            base_log2 <= base_nxt;
            best_log2 <= best_log2_nxt;
            best_ins  <= best_ins_nxt;
            best_cyc  <= best_cyc_nxt;
            best_en   <= best_en_nxt;
            hold_cnt  <= hold_cnt_nxt;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_req <= 1'b0;
        else        cfg_req <= (size_nxt != size_log2);
    end

    assign grp_count = GRP_W'(1) << (size_log2 - LOG_W'(GROUP_LOG2));

    assert_req_marks_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (grp_count != $past(grp_count)));

    assert_quiet_keeps_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req |-> $stable(grp_count));

    assert_size_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(grp_count) && size_log2 >= LOG_W'(MIN_LOG2) && size_log2 <= LOG_W'(MAX_LOG2));

    assert_steady_no_resize_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEADY) |=> !cfg_req);

    assert_round_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIAL_DBL && last) |=> (state == ST_STEADY));

    assert_trial_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIAL_CUR && last) |=> (state == ST_TRIAL_HALF));

endmodule

// File: tb/wsc_window_ctrl_test.sv
module wsc_window_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] commit_in = '0;
    logic [15:0] energy_in = '0;
    logic [7:0] hold_intervals = 8'd2;
    logic [4:0] grp_count;
    logic       cfg_req;

    int checks = 0;
    int failures = 0;
    int mode = 0;
    int cycles = 0;
    int pulses = 0;
    bit finished = 0;

    // reference model state
    int     m_state = 0;
    int     m_log = 9, m_base = 9, m_best_log = 9;
    longint m_ai = 0, m_ac = 0, m_ae = 0;
    longint m_bi = 0, m_bc = 0, m_be = 0;
    int     m_hold = 0;
    bit     m_req = 0;

    wsc_window_ctrl #(.INSN_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .commit_in(commit_in), .energy_in(energy_in),
        .hold_intervals(hold_intervals), .grp_count(grp_count), .cfg_req(cfg_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit beats(longint i, longint c, longint e,
                                 longint bi, longint bc, longint be);
        return (i*i*i*bc*bc*be) > (bi*bi*bi*c*c*e);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        longint ti, tc, te;
        int nl, goal;
        bit last, win;
        if (!rst_n) begin
            m_state = 0; m_log = 9; m_base = 9; m_best_log = 9;
            m_ai = 0; m_ac = 0; m_ae = 0; m_bi = 0; m_bc = 0; m_be = 0;
            m_hold = 0; m_req = 0;
        end else begin
            ti = m_ai + commit_in; tc = m_ac + 1; te = m_ae + energy_in;
            last = (ti >= LIMIT);
            if (last) begin m_ai = 0; m_ac = 0; m_ae = 0; end
            else begin m_ai = ti; m_ac = tc; m_ae = te; end
            nl = m_log;
            if (last) begin
                win = beats(ti, tc, te, m_bi, m_bc, m_be);
                if (m_state == 0) begin
                    goal = (hold_intervals == 0) ? 1 : int'(hold_intervals);
                    if (m_hold + 1 >= goal) begin m_state = 1; m_hold = 0; m_base = m_log; end
                    else m_hold++;
                end else if (m_state == 1) begin
                    m_best_log = m_base; m_bi = ti; m_bc = tc; m_be = te;
                    nl = (m_base > 7) ? m_base - 1 : m_base;
                    m_state = 2;
                end else if (m_state == 2) begin
                    if (win) begin m_best_log = m_log; m_bi = ti; m_bc = tc; m_be = te; end
                    nl = (m_base < 11) ? m_base + 1 : m_base;
                    m_state = 3;
                end else begin
                    if (win) begin m_best_log = m_log; m_bi = ti; m_bc = tc; m_be = te; end
                    nl = m_best_log;
                    m_state = 0;
                end
            end
            m_req = (nl != m_log);
            m_log = nl;
        end
    end

    // environment: drive inputs away from the rising edge
    always @(negedge clk) begin
        int g;
        g = $clog2(int'(grp_count));
        case (mode)
            1: begin commit_in <= 4'(g + 1); energy_in <= 16'd1; end
            2: begin commit_in <= 4'd2; energy_in <= 16'(grp_count); end
            default: begin commit_in <= 4'd2; energy_in <= 16'd1; end
        endcase
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(int'(grp_count) == (1 << (m_log - 7)), "R2 R4 R5 R6 R7 grp_count",
                  grp_count, 1 << (m_log - 7));
            check(cfg_req == m_req, "R4 cfg_req", cfg_req, m_req);
            check($onehot(grp_count) && grp_count >= 1 && grp_count <= 16, "R8 range",
                  grp_count, 0);
            if (cfg_req) pulses++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_steady();
        @(negedge clk);
        while (m_state != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(grp_count == 5'd4, "R1 reset grp_count", grp_count, 4);
        check(cfg_req == 1'b0, "R1 reset cfg_req", cfg_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grp_count == 5'd4 && cfg_req == 1'b0, "R1 after release", grp_count, 4);

        // equal figures at every size: current size retained
        mode = 0; pulses = 0;
        repeat (200) @(negedge clk);
        wait_steady();
        check(grp_count == 5'd4, "R7 tie keeps current", grp_count, 4);
        check(pulses >= 3 && pulses % 3 == 0, "R4 three requests per tie round", pulses, 3);

        // larger windows win: climb to the top and clamp
        mode = 1;
        repeat (400) @(negedge clk);
        wait_steady();
        check(grp_count == 5'd16, "R6 climbs to largest", grp_count, 16);
        check(grp_count == 5'd16, "R5 upper clamp holds", grp_count, 16);

        // smaller windows win: descend to the bottom and clamp
        mode = 2;
        repeat (600) @(negedge clk);
        wait_steady();
        check(grp_count == 5'd1, "R6 descends to smallest", grp_count, 1);
        check(grp_count == 5'd1, "R5 lower clamp holds", grp_count, 1);

        // long hold: no round starts inside the window
        hold_intervals = 8'd40; mode = 0;
        wait_steady();
        pulses = 0;
        repeat (100) @(negedge clk);
        check(pulses == 0, "R3 hold suppresses rounds", pulses, 0);

        // zero hold acts as one interval
        hold_intervals = 8'd0;
        repeat (300) @(negedge clk);
        pulses = 0;
        repeat (120) @(negedge clk);
        check(pulses > 0, "R3 zero hold still runs rounds", pulses, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule